// File: doc/BRIEF.md
# SPI Host Transaction Sequencer

This block is the host end of an SPI link to a display coprocessor that exposes a 22-bit memory space. A caller hands it one request at a time: a host command, a memory read or a memory write, each with an address (or a command code) and a byte count. The block frames the request on the wire, drives the serial clock, the master-out line and an active-low chip select, and samples the master-in line. Only SPI mode 0 is produced: the clock idles low, the master-out line changes while the clock is low, and the master-in line is sampled on the rising edge.

Each frame opens with a two-bit prefix that selects its kind. A command frame ends with two zero bytes. A read frame sends its three address bytes, then one dummy byte, and then as many bytes as requested. A write frame sends its three address bytes followed by data drawn from a byte stream. Read data leaves on a byte stream with a valid/ready handshake. The wire stalls between bytes, with the clock low and chip select held, when write data is missing or read data has not been taken. The serial clock half period is set by a divider input that is latched when a request is accepted.

Top module: `spi_txn_seq`

## Requirements
- R1: A command request (req_kind 0) sends exactly three bytes: {2'b01, req_addr[5:0]} and then 8'h00 twice. req_len is ignored.
- R2: A read request (req_kind 1) sends {2'b00, addr[21:16]}, addr[15:8] and addr[7:0], then one dummy byte of 8'h00. Every byte goes MSB first, and MISO during these four bytes is never delivered.
- R3: After the dummy byte, a read clocks req_len further bytes with MOSI at 8'h00. Each MISO byte is assembled MSB first and presented on rd_data in wire order. The next byte does not start while rd_valid is still pending.
- R4: A write request (req_kind 2) sends {2'b10, addr[21:16]}, addr[15:8] and addr[7:0], then req_len bytes taken from wr_data in arrival order, one per wr_valid/wr_ready handshake. The clock stays low while wr_valid is low.
- R5: cs_n stays low without a break from the first header bit to the last data bit of a frame. It is then high for at least one SCLK period (2*(clk_div+1) clock cycles) before the next frame.
- R6: Mode 0 timing holds throughout. SCLK is low when idle and when cs_n falls, and MOSI changes only while SCLK is low. Within a byte, consecutive rising edges of SCLK are 2*(clk_div+1) clock cycles apart.
- R7: A request is accepted only when busy is low and req_kind is not 3. busy then stays high until the post-frame gap has passed. Requests presented while busy, and req_kind 3 at any time, have no effect on the wire.
- R8: A read or write with req_len 0 sends only its header: four bytes for a read, three for a write.
- R9: Once rd_valid is high, it and rd_data hold steady until rd_ready is seen high.
- R10: Out of reset, cs_n is 1, sclk is 0, busy is 0 and rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 command, 1 read, 2 write, 3 reserved |
| req_addr | input | 22 | Memory address; bits 5:0 carry the command code |
| req_len | input | LEN_W | Data byte count for reads and writes |
| clk_div | input | DIV_W | SCLK half period minus one, in clock cycles |
| busy | output | 1 | High from acceptance until the frame gap ends |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken on this edge |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Master-out serial data |
| miso | input | 1 | Master-in serial data |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions assume that the read consumer never relies on rd_valid dropping without a handshake. They also assume that a new request is offered only while busy is low, since a request made while busy is simply dropped. The bench keeps clk_div fixed between issuing a request and the fall of busy, because the comparison of its period measurements uses the divider value that was latched. The slave model changes MISO only after a rising edge has been seen, so MISO is stable for a full half period before each sample.

// File: rtl/spi_txn_seq.sv
module spi_txn_seq #(
  parameter int DIV_W = 8,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [21:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [DIV_W-1:0] clk_div,
  output logic             busy,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam logic [1:0] K_CMD = 2'd0;
  localparam logic [1:0] K_RD  = 2'd1;
  localparam logic [1:0] K_WR  = 2'd2;
  localparam int GAP_W = DIV_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_GAP} st_t;

  st_t              st;
  logic [1:0]       kind_q;
  logic [21:0]      addr_q;
  logic [LEN_W-1:0] left_q;
  logic [2:0]       hidx;
  logic [DIV_W-1:0] div_q, div_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic [7:0]       sh, rx, rd_q;
  logic [2:0]       bitn;
  logic             sclk_q, cs_q, rdv_q, in_data;
  logic [2:0]       hdr_n;
  logic             in_hdr;
  logic [7:0]       hdr_byte;
  logic             accept;

  assign hdr_n    = (kind_q == K_RD) ? 3'd4 : 3'd3;
  assign in_hdr   = hidx < hdr_n;
  assign accept   = (st == S_IDLE) && req_valid && (req_kind != 2'b11);
  assign busy     = (st != S_IDLE);
  assign wr_ready = (st == S_LOAD) && !in_hdr && (left_q != '0) && (kind_q == K_WR);
  assign sclk     = sclk_q;
  assign cs_n     = cs_q;
  assign mosi     = cs_q ? 1'b0 : sh[7];
  assign rd_data  = rd_q;
  assign rd_valid = rdv_q;

  always_comb begin
    case (hidx)
      3'd0: case (kind_q)
              K_CMD:   hdr_byte = {2'b01, addr_q[5:0]};
              K_WR:    hdr_byte = {2'b10, addr_q[21:16]};
              default: hdr_byte = {2'b00, addr_q[21:16]};
            endcase
      3'd1:    hdr_byte = (kind_q == K_CMD) ? 8'h00 : addr_q[15:8];
      3'd2:    hdr_byte = (kind_q == K_CMD) ? 8'h00 : addr_q[7:0];
      default: hdr_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind_q  <= K_CMD;
      addr_q  <= '0;
      left_q  <= '0;
      hidx    <= '0;
      div_q   <= '0;
      div_cnt <= '0;
      gap_cnt <= '0;
      sh      <= '0;
      rx      <= '0;
      rd_q    <= '0;
      bitn    <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      rdv_q   <= 1'b0;
      in_data <= 1'b0;
    end else begin
      if (rdv_q && rd_ready) rdv_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          kind_q <= req_kind;
          addr_q <= req_addr;
          left_q <= (req_kind == K_CMD) ? '0 : req_len;
          div_q  <= clk_div;
          hidx   <= '0;
          cs_q   <= 1'b0;
          st     <= S_LOAD;
        end
        S_LOAD: begin
          div_cnt <= '0;
          bitn    <= '0;
          if (in_hdr) begin
            sh      <= hdr_byte;
            hidx    <= hidx + 3'd1;
            in_data <= 1'b0;
            st      <= S_SHIFT;
          end else if (left_q == '0) begin
            cs_q    <= 1'b1;
            gap_cnt <= '0;
            st      <= S_GAP;
          end else if (kind_q == K_WR && wr_valid) begin
            sh      <= wr_data;
            left_q  <= left_q - 1'b1;
            in_data <= 1'b1;
            st      <= S_SHIFT;
          end else if (kind_q == K_RD && !rdv_q) begin
            sh      <= 8'h00;
            left_q  <= left_q - 1'b1;
            in_data <= 1'b1;
            st      <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (div_cnt == div_q) begin
            div_cnt <= '0;
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rx     <= {rx[6:0], miso};
            end else begin
              sclk_q <= 1'b0;
              sh     <= {sh[6:0], 1'b0};
              bitn   <= bitn + 3'd1;
              if (bitn == 3'd7) begin
                st <= S_LOAD;
                if (in_data && kind_q == K_RD) begin
                  rd_q  <= rx;
                  rdv_q <= 1'b1;
                end
              end
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: begin
          if (gap_cnt == {div_q, 1'b1}) st <= S_IDLE;
          else gap_cnt <= gap_cnt + 1'b1;
        end
      endcase
    end
  end

  assert_idle_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk));

  assert_sclk_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> !cs_n);

  assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_accept_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(req_valid) && $past(req_kind) != 2'b11));
endmodule

// File: tb/tb_spi_txn_seq.sv
module tb_spi_txn_seq;
  localparam int DIV_W = 8;
  localparam int LEN_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [21:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [DIV_W-1:0] clk_div = '0;
  logic busy, wr_ready, rd_valid, sclk, mosi, cs_n;
  logic [7:0] wr_data = '0;
  logic wr_valid = 1'b0;
  logic [7:0] rd_data;
  logic rd_ready = 1'b0;
  logic miso = 1'b0;

  always #2 clk = ~clk;

  spi_txn_seq #(.DIV_W(DIV_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len), .clk_div(clk_div), .busy(busy),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  int tests = 0;
  int fails = 0;

  logic [7:0] exp_mosi[$];
  string      exp_tag[$];
  logic [7:0] exp_rd[$];
  int         exp_flen[$];
  logic [7:0] wr_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sbyte(input int k);
    return 8'h3C + 8'(k * 37);
  endfunction

  // monitor, slave model and stream feeders
  bit mon_on = 1'b0;
  logic prev_sclk = 1'b0, prev_cs = 1'b1, took = 1'b0;
  logic prev_rdv = 1'b0, prev_rdr = 1'b0;
  logic [7:0] prev_rdd = '0;
  logic [7:0] mbyte = '0;
  int bitpos = 0, fbytes = 0, since_rise = 0, hi_cnt = 0;
  int cyc = 0, frame_div = 0, cur_div = 0, slv_p = 0;
  bit had_frame = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (took && wr_q.size() > 0) void'(wr_q.pop_front());
    wr_valid = (wr_q.size() > 0) && (cyc % 5 != 0);
    wr_data  = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
    took     = wr_valid && wr_ready;
    rd_ready = (cyc % 4 != 1);
    if (mon_on) begin
      since_rise++;
      if (prev_rdv && !prev_rdr)
        chk(rd_valid && rd_data == prev_rdd, "R9 rd hold", {rd_valid, rd_data}, {1'b1, prev_rdd});
      if (rd_valid && rd_ready) begin
        if (exp_rd.size() == 0) chk(1'b0, "R3 unexpected read byte", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rd.pop_front();
          chk(rd_data == e, "R3 read data", rd_data, e);
        end
      end
      if (prev_cs && !cs_n) begin
        chk(!sclk, "R6 sclk low at cs fall", sclk, 0);
        if (had_frame)
          chk(hi_cnt >= 2 * (frame_div + 1), "R5 cs gap", hi_cnt, 2 * (frame_div + 1));
        had_frame = 1'b1;
        frame_div = cur_div;
        bitpos = 0; fbytes = 0; slv_p = 0;
      end
      if (cs_n) hi_cnt++;
      else hi_cnt = 0;
      if (!prev_cs && cs_n) begin
        if (exp_flen.size() == 0) chk(1'b0, "R5 unexpected frame", fbytes, 0);
        else begin
          int fl;
          fl = exp_flen.pop_front();
          chk(fbytes == fl, "R8 frame length", fbytes, fl);
        end
        hi_cnt = 1;
      end
      if (!prev_sclk && sclk) begin
        chk(!cs_n, "R5 sclk with cs low", cs_n, 0);
        if (bitpos % 8 != 0)
          chk(since_rise == 2 * (frame_div + 1), "R6 sclk period", since_rise, 2 * (frame_div + 1));
        since_rise = 0;
        mbyte = {mbyte[6:0], mosi};
        bitpos++;
        slv_p++;
        if (bitpos % 8 == 0) begin
          fbytes++;
          if (exp_mosi.size() == 0) chk(1'b0, "R4 unexpected mosi byte", mbyte, 0);
          else begin
            logic [7:0] e;
            string t;
            e = exp_mosi.pop_front();
            t = exp_tag.pop_front();
            chk(mbyte == e, t, mbyte, e);
          end
        end
      end
    end
    begin
      logic [7:0] sb;
      sb = sbyte(slv_p / 8);
      miso = sb[7 - (slv_p % 8)];
    end
    prev_sclk = sclk; prev_cs = cs_n;
    prev_rdv = rd_valid; prev_rdr = rd_ready; prev_rdd = rd_data;
  end

  task automatic issue(input logic [1:0] kind, input logic [21:0] addr,
                       input int len, input int div, input logic [7:0] seed);
    while (busy) @(negedge clk);
    cur_div = div;
    clk_div = DIV_W'(div);
    if (kind == 2'd0) begin
      exp_mosi.push_back({2'b01, addr[5:0]}); exp_tag.push_back("R1 cmd byte");
      exp_mosi.push_back(8'h00); exp_tag.push_back("R1 pad");
      exp_mosi.push_back(8'h00); exp_tag.push_back("R1 pad");
      exp_flen.push_back(3);
    end else begin
      exp_mosi.push_back({(kind == 2'd1) ? 2'b00 : 2'b10, addr[21:16]});
      exp_tag.push_back(kind == 2'd1 ? "R2 rd hdr" : "R4 wr hdr");
      exp_mosi.push_back(addr[15:8]); exp_tag.push_back("R2 addr mid");
      exp_mosi.push_back(addr[7:0]);  exp_tag.push_back("R2 addr low");
      if (kind == 2'd1) begin
        exp_mosi.push_back(8'h00); exp_tag.push_back("R2 dummy");
        for (int i = 0; i < len; i++) begin
          exp_mosi.push_back(8'h00); exp_tag.push_back("R3 rd mosi zero");
          exp_rd.push_back(sbyte(4 + i));
        end
        exp_flen.push_back(4 + len);
      end else begin
        for (int i = 0; i < len; i++) begin
          logic [7:0] b;
          b = seed + 8'(i * 19);
          wr_q.push_back(b);
          exp_mosi.push_back(b); exp_tag.push_back("R4 wr data");
        end
        exp_flen.push_back(3 + len);
      end
    end
    req_kind = kind; req_addr = addr; req_len = LEN_W'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R7 busy after accept", busy, 1);
  endtask

  task automatic run_tests();
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !rd_valid, "R10 reset state",
        {cs_n, sclk, busy, rd_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    issue(2'd0, 22'h3FFFEA, 7, 1, 8'h00);
    issue(2'd1, 22'h012345, 4, 2, 8'h00);
    issue(2'd2, 22'h3F00A5, 4, 1, 8'h11);
    issue(2'd1, 22'h2ABCDE, 0, 0, 8'h00);
    issue(2'd2, 22'h000001, 0, 3, 8'h00);
    issue(2'd2, 22'h155555, 1, 0, 8'hC3);
    issue(2'd1, 22'h3FFFFF, 2, 0, 8'h00);
    // R7: request while busy must not start anything
    issue(2'd1, 22'h100200, 3, 2, 8'h00);
    repeat (6) @(negedge clk);
    req_kind = 2'd2; req_addr = 22'h0ABCDE; req_len = 5; req_valid = 1'b1;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R7 still busy", busy, 1);
    while (busy) @(negedge clk);
    // R7: reserved kind never accepted
    req_kind = 2'd3; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && cs_n, "R7 kind 3 ignored", {busy, cs_n}, 2'b01);
    req_valid = 1'b0;
    @(negedge clk);
    issue(2'd2, 22'h2468AC, 16, 1, 8'h5A);
    issue(2'd0, 22'h000015, 0, 4, 8'h00);
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(exp_mosi.size() == 0, "R4 all mosi bytes seen", exp_mosi.size(), 0);
    chk(exp_rd.size() == 0, "R3 all read bytes seen", exp_rd.size(), 0);
    chk(exp_flen.size() == 0, "R5 all frames seen", exp_flen.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R7 watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule